// File: doc/BRIEF.md
# Self-Describing Bus Table Walker

This block is a small bus master that searches a self-description table held in a memory-mapped ROM for one particular peripheral. The table is a run of 64-byte records. Its first record is a header that carries an identification word, a record count and a format version. Each record after the header is typed by its last byte. The walker is given a root table address, a 64-bit vendor identifier and a 32-bit device identifier. It then reads the ROM one 32-bit word at a time through a request/acknowledge port and dispatches on each record type.

Bridge records lead to nested sub-bus tables. The walker descends into them while keeping up to four enclosing positions on a stack. Each nested table sits in its own address space, offset by the bridge's first address. On the first matching device record the walker returns that device's first and last byte addresses, translated to the root address space. Otherwise it returns a status code for an exhausted search, a bad identification word or a bad format version.

Two sticky flags report what the walk skipped along the way. One flag marks unknown component-range record types. The other marks bridges that were not followed because the stack was full.

Top module: `dir_walker`

## Requirements
- R1: A one-cycle `start` while `busy` is low latches `rootAddr`, `vendorId` and `deviceId` and begins a walk. `busy` is high from the next cycle until the walk ends. Each walk ends with `done` high for exactly one cycle, with `busy` low in that cycle. A `start` while `busy` is high has no effect.
- R2: Each read holds `rdReq` high with `rdAddr` stable until a cycle with `rdAck` high, and the data is taken from `rdData` in that cycle. `rdAddr` is the byte address divided by four. The first read of a walk is at word `rootAddr/4`. `rdReq` is low whenever `busy` is low.
- R3: The first word of every table, both the root and any child, must equal 0x5344422D. Otherwise the walk ends at once with `status` 2.
- R4: The header word at byte offset 4 holds the record count in bits 31:16, and this count includes the header itself. Bits 15:8 of that word hold the format version, which must be 1; any other version ends the walk with `status` 3. Records 1 to count-1 are visited in order.
- R5: Record n of a table sits at table base + 64·n. Its type is bits 7:0 of the word at record offset 0x3C, and only this word is read before the type is known.
- R6: A type 0x01 record matches when the words at offsets 0x18 (vendor high), 0x1C (vendor low) and 0x20 (device) equal the targets. On the first match the walk ends with `status` 0 and reads nothing more. `devFirst` is the current space base plus the word at 0x0C, and `devLast` is the current space base plus the word at 0x14. These are the low halves of the 64-bit addresses.
- R7: For a type 0x02 record, the child table is at the current space base plus the word at 0x04. The child's space base is the current space base plus the word at 0x0C. The root space base is 0. When the child table is exhausted, the walk resumes at the record after the bridge.
- R8: With four levels of bridges already open, a further bridge is skipped and `ovfFlag` is set.
- R9: Types 0x00 and 0x80–0xFF are skipped silently. Types 0x03–0x7F are skipped and set `warnFlag`. Both flags are sticky and are cleared by an accepted `start`.
- R10: When the root table is exhausted with no match, the walk ends with `status` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (one cycle) |
| rootAddr | input | 32 | Byte address of the root table |
| vendorId | input | 64 | Target vendor identifier |
| deviceId | input | 32 | Target device identifier |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| status | output | 2 | 0 found, 1 not found, 2 bad identification word, 3 bad version |
| devFirst | output | 32 | Absolute first address of the match |
| devLast | output | 32 | Absolute last address of the match (inclusive) |
| warnFlag | output | 1 | Unknown component-range type seen |
| ovfFlag | output | 1 | Bridge skipped for stack depth |
| rdReq | output | 1 | Read request |
| rdAddr | output | 30 | Read word address |
| rdAck | input | 1 | Read acknowledge, data valid |
| rdData | input | 32 | Read data |

## Verification
The hardest state to reach from the ports is a full stack. It requires five nested tables whose child pointers and bridge bases all agree under relative addressing. After a bridge is skipped, the walk must still unwind and resume correctly in the root table. The bench builds such chains with a loop that derives each child pointer from the level's space base. It places a reachable device after the root bridge, so the unwound walk must find that device. Randomly built two-level tables are answered with random read latency and compared against a bench walk model.

// File: rtl/dir_walker_pkg.sv
package dir_walker_pkg;

  localparam logic [31:0] TABLE_MAGIC = 32'h5344_422D;
  localparam logic [7:0]  FMT_VERSION = 8'd1;
  localparam logic [7:0]  TYPE_HEADER = 8'h00;
  localparam logic [7:0]  TYPE_DEVICE = 8'h01;
  localparam logic [7:0]  TYPE_BRIDGE = 8'h02;

  // Which 32-bit word of a table or record the next read targets
  typedef enum logic [3:0] {
    F_MAGIC, F_HDR, F_TYPE, F_VHI, F_VLO, F_DID, F_FIRST, F_LAST, F_CHILD
  } fieldSel_t;

  typedef enum logic [1:0] {
    ST_FOUND   = 2'd0,
    ST_NONE    = 2'd1,
    ST_MAGIC   = 2'd2,
    ST_VERSION = 2'd3
  } walkStatus_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    fieldSel_t field;
    logic      initRoot;
    logic      capHdr;
    logic      capChild;
    logic      push;
    logic      pop;
    logic      nextRec;
    logic      capFirst;
    logic      capLast;
    logic      setWarn;
    logic      setOvf;
  } dpCtl_t;

  function automatic logic [5:0] fieldOffset(fieldSel_t f);
    case (f)
      F_MAGIC: return 6'h00;
      F_HDR:   return 6'h04;
      F_TYPE:  return 6'h3C;
      F_VHI:   return 6'h18;
      F_VLO:   return 6'h1C;
      F_DID:   return 6'h20;
      F_FIRST: return 6'h0C;
      F_LAST:  return 6'h14;
      F_CHILD: return 6'h04;
      default: return 6'h00;
    endcase
  endfunction

endpackage

// File: rtl/dir_walker_dp.sv
module dir_walker_dp
  import dir_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [31:0]       rdData,
  input  logic [ADDR_W-1:0] rootAddr,
  input  logic [63:0]       vendorId,
  input  logic [31:0]       deviceId,
  output logic [ADDR_W-3:0] rdAddr,
  output logic              magicOk,
  output logic              versionOk,
  output logic              recEnd,
  output logic              stackEmpty,
  output logic              stackFull,
  output logic [7:0]        recType,
  output logic              vendHiOk,
  output logic              vendLoOk,
  output logic              devOk,
  output logic [ADDR_W-1:0] devFirst,
  output logic [ADDR_W-1:0] devLast,
  output logic              warnFlag,
  output logic              ovfFlag
);

  localparam int SP_W      = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W     = $clog2(STACK_DEPTH);
  localparam int CNT_W     = 16;
  localparam int REC_SHIFT = 6;

  typedef struct packed {
    logic [CNT_W-1:0]  resumeIdx;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] tblBase;
    logic [ADDR_W-1:0] spaceBase;
  } frame_t;

  logic [ADDR_W-1:0] tblBase, spaceBase, childRel;
  logic [CNT_W-1:0]  recIdx, recCount;
  logic [SP_W-1:0]   sp;
  logic [63:0]       tgtVendor;
  logic [31:0]       tgtDevice;
  frame_t            frames [STACK_DEPTH];
  frame_t            popFrame;
  logic [STACK_DEPTH-1:0] slotWr;

  logic [ADDR_W-1:0] recBase, byteAddr, offset;
  logic [1:0]        unusedLowBits;

  // Address generation: header words are relative to the table base,
  // all other fields to the current record base.
  assign recBase  = tblBase + (ADDR_W'(recIdx) << REC_SHIFT);
  assign offset   = ADDR_W'(fieldOffset(ctl.field));
  assign byteAddr = ((ctl.field == F_MAGIC) || (ctl.field == F_HDR))
                    ? tblBase + offset : recBase + offset;
  assign rdAddr        = byteAddr[ADDR_W-1:2];
  assign unusedLowBits = byteAddr[1:0];

  // Comparisons on the word being acknowledged
  assign magicOk   = (rdData == TABLE_MAGIC);
  assign versionOk = (rdData[15:8] == FMT_VERSION);
  assign recType   = rdData[7:0];
  assign vendHiOk  = (rdData == tgtVendor[63:32]);
  assign vendLoOk  = (rdData == tgtVendor[31:0]);
  assign devOk     = (rdData == tgtDevice);

  assign recEnd     = (recIdx >= recCount);
  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign popFrame   = frames[IDX_W'(sp - SP_W'(1))];

  generate
    for (genvar e = 0; e < STACK_DEPTH; e++) begin : g_slot
      assign slotWr[e] = ctl.push && (sp == SP_W'(e));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < STACK_DEPTH; e++) frames[e] <= '0;
    end else begin
      for (int e = 0; e < STACK_DEPTH; e++) begin
        if (slotWr[e]) begin
          frames[e] <= '{resumeIdx: recIdx + CNT_W'(1), count: recCount,
                         tblBase: tblBase, spaceBase: spaceBase};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblBase   <= '0;
      spaceBase <= '0;
      childRel  <= '0;
      recIdx    <= '0;
      recCount  <= '0;
      sp        <= '0;
      tgtVendor <= '0;
      tgtDevice <= '0;
      devFirst  <= '0;
      devLast   <= '0;
      warnFlag  <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (ctl.initRoot) begin
        tblBase   <= rootAddr;
        spaceBase <= '0;
        sp        <= '0;
        recIdx    <= '0;
        recCount  <= '0;
        tgtVendor <= vendorId;
        tgtDevice <= deviceId;
        devFirst  <= '0;
        devLast   <= '0;
        warnFlag  <= 1'b0;
        ovfFlag   <= 1'b0;
      end
      if (ctl.capHdr) begin
        recCount <= rdData[31:16];
        recIdx   <= CNT_W'(1);
      end
      if (ctl.nextRec) recIdx <= recIdx + CNT_W'(1);
      if (ctl.capChild) childRel <= rdData[ADDR_W-1:0];
      if (ctl.push) begin
        sp        <= sp + SP_W'(1);
        tblBase   <= spaceBase + childRel;
        spaceBase <= spaceBase + rdData[ADDR_W-1:0];
      end
      if (ctl.pop) begin
        sp        <= sp - SP_W'(1);
        recIdx    <= popFrame.resumeIdx;
        recCount  <= popFrame.count;
        tblBase   <= popFrame.tblBase;
        spaceBase <= popFrame.spaceBase;
      end
      if (ctl.capFirst) devFirst <= spaceBase + rdData[ADDR_W-1:0];
      if (ctl.capLast)  devLast  <= spaceBase + rdData[ADDR_W-1:0];
      if (ctl.setWarn)  warnFlag <= 1'b1;
      if (ctl.setOvf)   ovfFlag  <= 1'b1;
    end
  end

endmodule

// File: rtl/dir_walker_ctrl.sv
module dir_walker_ctrl
  import dir_walker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rdAck,
  input  logic       magicOk,
  input  logic       versionOk,
  input  logic       recEnd,
  input  logic       stackEmpty,
  input  logic       stackFull,
  input  logic [7:0] recType,
  input  logic       vendHiOk,
  input  logic       vendLoOk,
  input  logic       devOk,
  output dpCtl_t     ctl,
  output logic       rdReq,
  output logic       busy,
  output logic       done,
  output logic [1:0] status
);

  typedef enum logic [3:0] {
    S_IDLE, S_MAGIC, S_HDR, S_SCAN, S_TYPE, S_VHI, S_VLO, S_DID,
    S_FIRST, S_LAST, S_CHILD, S_BFIRST
  } walkState_t;

  walkState_t  state, nextState;
  logic        finNow;
  walkStatus_t finCode;

  assign busy = (state != S_IDLE);

  always_comb begin
    ctl       = '0;
    ctl.field = F_TYPE;
    nextState = state;
    finNow    = 1'b0;
    finCode   = ST_NONE;
    rdReq     = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.initRoot = 1'b1;
          nextState    = S_MAGIC;
        end
      end
      S_MAGIC: begin
        rdReq     = 1'b1;
        ctl.field = F_MAGIC;
        if (rdAck) begin
          if (magicOk) nextState = S_HDR;
          else begin
            finNow    = 1'b1;
            finCode   = ST_MAGIC;
            nextState = S_IDLE;
          end
        end
      end
      S_HDR: begin
        rdReq     = 1'b1;
        ctl.field = F_HDR;
        if (rdAck) begin
          if (versionOk) begin
            ctl.capHdr = 1'b1;
            nextState  = S_SCAN;
          end else begin
            finNow    = 1'b1;
            finCode   = ST_VERSION;
            nextState = S_IDLE;
          end
        end
      end
      S_SCAN: begin
        if (recEnd) begin
          if (stackEmpty) begin
            finNow    = 1'b1;
            finCode   = ST_NONE;
            nextState = S_IDLE;
          end else begin
            ctl.pop = 1'b1;
          end
        end else begin
          nextState = S_TYPE;
        end
      end
      S_TYPE: begin
        rdReq     = 1'b1;
        ctl.field = F_TYPE;
        if (rdAck) begin
          if (recType == TYPE_DEVICE) begin
            nextState = S_VHI;
          end else if (recType == TYPE_BRIDGE) begin
            if (stackFull) begin
              ctl.setOvf  = 1'b1;
              ctl.nextRec = 1'b1;
              nextState   = S_SCAN;
            end else begin
              nextState = S_CHILD;
            end
          end else begin
            ctl.nextRec = 1'b1;
            ctl.setWarn = (recType != TYPE_HEADER) && !recType[7];
            nextState   = S_SCAN;
          end
        end
      end
      S_VHI: begin
        rdReq     = 1'b1;
        ctl.field = F_VHI;
        if (rdAck) begin
          if (vendHiOk) nextState = S_VLO;
          else begin
            ctl.nextRec = 1'b1;
            nextState   = S_SCAN;
          end
        end
      end
      S_VLO: begin
        rdReq     = 1'b1;
        ctl.field = F_VLO;
        if (rdAck) begin
          if (vendLoOk) nextState = S_DID;
          else begin
            ctl.nextRec = 1'b1;
            nextState   = S_SCAN;
          end
        end
      end
      S_DID: begin
        rdReq     = 1'b1;
        ctl.field = F_DID;
        if (rdAck) begin
          if (devOk) nextState = S_FIRST;
          else begin
            ctl.nextRec = 1'b1;
            nextState   = S_SCAN;
          end
        end
      end
      S_FIRST: begin
        rdReq     = 1'b1;
        ctl.field = F_FIRST;
        if (rdAck) begin
          ctl.capFirst = 1'b1;
          nextState    = S_LAST;
        end
      end
      S_LAST: begin
        rdReq     = 1'b1;
        ctl.field = F_LAST;
        if (rdAck) begin
          ctl.capLast = 1'b1;
          finNow      = 1'b1;
          finCode     = ST_FOUND;
          nextState   = S_IDLE;
        end
      end
      S_CHILD: begin
        rdReq     = 1'b1;
        ctl.field = F_CHILD;
        if (rdAck) begin
          ctl.capChild = 1'b1;
          nextState    = S_BFIRST;
        end
      end
      S_BFIRST: begin
        rdReq     = 1'b1;
        ctl.field = F_FIRST;
        if (rdAck) begin
          ctl.push  = 1'b1;
          nextState = S_MAGIC;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      status <= 2'd0;
    end else begin
      state <= nextState;
      done  <= finNow;
      if (finNow) status <= finCode;
    end
  end

endmodule

// File: rtl/dir_walker.sv
module dir_walker
  import dir_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] rootAddr,
  input  logic [63:0]       vendorId,
  input  logic [31:0]       deviceId,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] devFirst,
  output logic [ADDR_W-1:0] devLast,
  output logic              warnFlag,
  output logic              ovfFlag,
  output logic              rdReq,
  output logic [ADDR_W-3:0] rdAddr,
  input  logic              rdAck,
  input  logic [31:0]       rdData
);

  dpCtl_t     ctl;
  logic       magicOk, versionOk, recEnd, stackEmpty, stackFull;
  logic       vendHiOk, vendLoOk, devOk;
  logic [7:0] recType;

  dir_walker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdAck(rdAck),
    .magicOk(magicOk), .versionOk(versionOk), .recEnd(recEnd),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .recType(recType),
    .vendHiOk(vendHiOk), .vendLoOk(vendLoOk), .devOk(devOk),
    .ctl(ctl), .rdReq(rdReq), .busy(busy), .done(done), .status(status)
  );

  dir_walker_dp #(.ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(rdData),
    .rootAddr(rootAddr), .vendorId(vendorId), .deviceId(deviceId),
    .rdAddr(rdAddr), .magicOk(magicOk), .versionOk(versionOk),
    .recEnd(recEnd), .stackEmpty(stackEmpty), .stackFull(stackFull),
    .recType(recType), .vendHiOk(vendHiOk), .vendLoOk(vendLoOk),
    .devOk(devOk), .devFirst(devFirst), .devLast(devLast),
    .warnFlag(warnFlag), .ovfFlag(ovfFlag)
  );

endmodule

// File: rtl/dir_walker_chk.sv
module dir_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              warnFlag,
  input logic              ovfFlag,
  input logic              rdReq,
  input logic [ADDR_W-3:0] rdAddr,
  input logic              rdAck
);

  // R1: done lasts one cycle
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: the walk has ended when done is shown
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R1: an accepted start makes the walker busy
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2: request held with a stable address until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr)));

  // R2: no reads outside a walk
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq);

  // R8: overflow flag is sticky until a new start
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !start) |=> ovfFlag);

  // R9: warning flag is sticky until a new start
  a_r9_warn_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (warnFlag && !start) |=> warnFlag);

endmodule

bind dir_walker dir_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .warnFlag(warnFlag), .ovfFlag(ovfFlag), .rdReq(rdReq), .rdAddr(rdAddr),
  .rdAck(rdAck)
);

// File: tb/dir_walker_bench.sv
module dir_walker_bench;

  localparam logic [31:0] MAGIC = 32'h5344_422D;
  localparam int MEM_WORDS = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] rootAddr = '0;
  logic [63:0] vendorId = '0;
  logic [31:0] deviceId = '0;
  logic        busy, done, warnFlag, ovfFlag, rdReq;
  logic [1:0]  status;
  logic [31:0] devFirst, devLast;
  logic [29:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [31:0] rdData = '0;

  logic [31:0] mem [MEM_WORDS];
  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  int ackDelay = 0;

  logic [1:0]  gotStatus;
  logic [31:0] gotFirst, gotLast;
  logic        gotWarn, gotOvf, gotDone, sawBusy, reqAfter, firstReq;
  logic [29:0] firstReqAddr;

  localparam logic [63:0] VA = 64'h8000_0001_0000_000A;
  localparam logic [63:0] VB = 64'h8000_0001_0000_000B;

  dir_walker u_dir_walker (
    .clk(clk), .rstN(rstN), .start(start), .rootAddr(rootAddr),
    .vendorId(vendorId), .deviceId(deviceId), .busy(busy), .done(done),
    .status(status), .devFirst(devFirst), .devLast(devLast),
    .warnFlag(warnFlag), .ovfFlag(ovfFlag), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdAck(rdAck), .rdData(rdData)
  );

  always #4 clk = ~clk;

  // ROM responder with random latency
  initial begin
    forever begin
      @(posedge clk);
      cycles <= cycles + 1;
      if (rdAck) rdAck <= 1'b0;
      else if (rdReq) begin
        if (ackDelay > 0) ackDelay <= ackDelay - 1;
        else begin
          rdAck    <= 1'b1;
          rdData   <= mem[rdAddr[11:0]];
          ackDelay <= int'($urandom % 4);
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    wait (cycles >= 190000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memRd(input logic [31:0] a);
    return mem[a[13:2]];
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    mem[a[13:2]] = d;
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = $urandom;
  endtask

  task automatic fillRec(input logic [31:0] a);
    for (int i = 0; i < 16; i++) wr(a + 32'(4*i), $urandom);
  endtask

  task automatic putHdr(input logic [31:0] a, input int cnt, input logic [7:0] ver,
                        input logic [31:0] magic);
    fillRec(a);
    wr(a, magic);
    wr(a + 4, {cnt[15:0], ver, 8'h01});
    wr(a + 32'h3C, 32'h2020_2000);
  endtask

  task automatic putDev(input logic [31:0] a, input logic [63:0] v, input logic [31:0] d,
                        input logic [31:0] first, input logic [31:0] last);
    fillRec(a);
    wr(a + 32'h08, 32'h0); wr(a + 32'h0C, first);
    wr(a + 32'h10, 32'h0); wr(a + 32'h14, last);
    wr(a + 32'h18, v[63:32]); wr(a + 32'h1C, v[31:0]);
    wr(a + 32'h20, d);
    wr(a + 32'h3C, 32'h2020_2001);
  endtask

  task automatic putBridge(input logic [31:0] a, input logic [31:0] childRel,
                           input logic [31:0] first);
    fillRec(a);
    wr(a + 32'h00, 32'h0); wr(a + 32'h04, childRel);
    wr(a + 32'h08, 32'h0); wr(a + 32'h0C, first);
    wr(a + 32'h10, 32'h0); wr(a + 32'h14, first + 32'hFF);
    wr(a + 32'h3C, 32'h2020_2002);
  endtask

  task automatic putOther(input logic [31:0] a, input logic [7:0] t);
    fillRec(a);
    wr(a + 32'h3C, {24'h202020, t});
  endtask

  // Bench walk model built from the requirements
  task automatic refWalk(input logic [31:0] root, input logic [63:0] v, input logic [31:0] d,
                         output logic [1:0] st, output logic [31:0] f, output logic [31:0] l,
                         output logic w, output logic o);
    logic [31:0] tb, sb, cnt, idx, rb, hw, nt;
    logic [31:0] fIdx [4], fCnt [4], fTb [4], fSb [4];
    logic [7:0]  t;
    int sp;
    bit needHdr;
    tb = root; sb = 0; sp = 0; needHdr = 1;
    w = 0; o = 0; f = 0; l = 0; st = 2'd1; cnt = 0; idx = 0;
    for (int guard = 0; guard < 5000; guard++) begin
      if (needHdr) begin
        if (memRd(tb) != MAGIC) begin st = 2'd2; f = 0; l = 0; return; end
        hw = memRd(tb + 4);
        if (hw[15:8] != 8'd1) begin st = 2'd3; f = 0; l = 0; return; end
        cnt = {16'h0, hw[31:16]}; idx = 1; needHdr = 0;
      end
      if (idx >= cnt) begin
        if (sp == 0) begin st = 2'd1; return; end
        sp--;
        idx = fIdx[sp]; cnt = fCnt[sp]; tb = fTb[sp]; sb = fSb[sp];
      end else begin
        rb = tb + (idx << 6);
        t = memRd(rb + 32'h3C) & 8'hFF;
        idx++;
        if (t == 8'h01) begin
          if (memRd(rb + 32'h18) == v[63:32] && memRd(rb + 32'h1C) == v[31:0] &&
              memRd(rb + 32'h20) == d) begin
            f = sb + memRd(rb + 32'h0C);
            l = sb + memRd(rb + 32'h14);
            st = 2'd0;
            return;
          end
        end else if (t == 8'h02) begin
          if (sp == 4) o = 1;
          else begin
            fIdx[sp] = idx; fCnt[sp] = cnt; fTb[sp] = tb; fSb[sp] = sb; sp++;
            nt = sb + memRd(rb + 32'h04);
            sb = sb + memRd(rb + 32'h0C);
            tb = nt; needHdr = 1;
          end
        end else if (t >= 8'h03 && t < 8'h80) w = 1;
      end
    end
  endtask

  task automatic runWalk(input logic [31:0] root, input logic [63:0] v,
                         input logic [31:0] d, input bit disturb);
    int waitCnt;
    @(negedge clk);
    start = 1'b1; rootAddr = root; vendorId = v; deviceId = d;
    @(negedge clk);
    start = 1'b0;
    sawBusy = busy;
    firstReq = rdReq;
    firstReqAddr = rdAddr;
    if (disturb) begin
      start = 1'b1; rootAddr = 32'h3FC0; vendorId = VB; deviceId = 32'h99;
      @(negedge clk);
      start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    gotDone = done; gotStatus = status; gotFirst = devFirst; gotLast = devLast;
    gotWarn = warnFlag; gotOvf = ovfFlag;
    @(negedge clk);
    reqAfter = rdReq;
  endtask

  task automatic expectWalk(input string tag, input logic [1:0] st, input logic [31:0] f,
                            input logic [31:0] l, input logic w, input logic o);
    chk(gotDone == 1'b1, tag, "done seen", 64'(gotDone), 64'd1);
    chk(gotStatus == st, tag, "status", 64'(gotStatus), 64'(st));
    if (st == 2'd0) begin
      chk(gotFirst == f, tag, "devFirst", 64'(gotFirst), 64'(f));
      chk(gotLast == l, tag, "devLast", 64'(gotLast), 64'(l));
    end
    chk(gotWarn == w, tag, "warnFlag", 64'(gotWarn), 64'(w));
    chk(gotOvf == o, tag, "ovfFlag", 64'(gotOvf), 64'(o));
  endtask

  // Nested chain: level L table at L*0x400, space base L*0x100
  task automatic buildChain(input int levels, input logic [31:0] devId, input bit rootDev);
    for (int lvl = 0; lvl <= levels; lvl++) begin
      logic [31:0] tbl, spc;
      tbl = 32'(lvl * 32'h400);
      spc = 32'(lvl * 32'h100);
      if (lvl < levels) begin
        putHdr(tbl, (lvl == 0 && rootDev) ? 3 : 2, 8'd1, MAGIC);
        putBridge(tbl + 64, 32'((lvl + 1) * 32'h400) - spc, 32'h100);
        if (lvl == 0 && rootDev) putDev(tbl + 128, VA, devId, 32'h700, 32'h7FF);
      end else begin
        putHdr(tbl, 2, 8'd1, MAGIC);
        putDev(tbl + 64, VA, devId, 32'h20, 32'h3F);
      end
    end
  endtask

  task automatic randRec(input logic [31:0] a, input int level);
    int kind;
    logic [63:0] v;
    logic [31:0] d, fst;
    kind = int'($urandom % 6);
    v = {32'h8000_0001 + 32'($urandom % 2), 32'hA + 32'($urandom % 2)};
    d = 32'h10 + 32'($urandom % 2);
    fst = ($urandom & 32'hFFF0);
    case (kind)
      0, 1: putDev(a, v, d, fst, fst + 32'hF);
      2: begin
        if (level == 0) putBridge(a, 32'h800, 32'h100);
        else if (level == 1) putBridge(a, 32'hF00, 32'(($urandom % 8) * 32'h1000));
        else putOther(a, 8'h7A);
      end
      3: putOther(a, 8'h03 + 8'($urandom % 8'h7D));
      4: putOther(a, 8'h80 + 8'($urandom % 8'h80));
      default: putOther(a, 8'h00);
    endcase
  endtask

  task automatic randTable(input logic [31:0] tbl, input int level);
    int n;
    logic [7:0] ver;
    logic [31:0] mg;
    n = 2 + int'($urandom % 6);
    ver = ($urandom % 10 == 0) ? 8'd3 : 8'd1;
    mg = ($urandom % 10 == 0) ? 32'h1234_5678 : MAGIC;
    if (level == 0) begin ver = 8'd1; mg = MAGIC; end
    putHdr(tbl, n, ver, mg);
    for (int i = 1; i < n; i++) randRec(tbl + 32'(64 * i), level);
  endtask

  initial begin
    logic [1:0]  eSt;
    logic [31:0] eF, eL;
    logic        eW, eO;
    void'($urandom(32'd1234));
    clearMem();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {busy, done}, 0);
    chk(rdReq == 1'b0, "R2", "no request after reset", 64'(rdReq), 0);

    // R6 R5 R9 R1: flat table, match at record 2 after a silent type; start while busy ignored
    clearMem();
    putHdr(0, 4, 8'd1, MAGIC);
    putOther(64, 8'h90);
    putDev(128, VA, 32'h10, 32'h5000, 32'h50FF);
    putDev(192, VB, 32'h10, 32'h6000, 32'h60FF);
    runWalk(0, VA, 32'h10, 1);
    chk(sawBusy == 1'b1, "R1", "busy after start", 64'(sawBusy), 1);
    expectWalk("R6", 2'd0, 32'h5000, 32'h50FF, 0, 0);
    chk(reqAfter == 1'b0, "R6", "no read after match", 64'(reqAfter), 0);
    runWalk(0, VB, 32'h10, 0);
    expectWalk("R5", 2'd0, 32'h6000, 32'h60FF, 0, 0);

    // R2 R6: table away from zero, duplicate IDs, first one wins
    clearMem();
    putHdr(32'h3000, 3, 8'd1, MAGIC);
    putDev(32'h3040, VA, 32'h10, 32'h100, 32'h1FF);
    putDev(32'h3080, VA, 32'h10, 32'h200, 32'h2FF);
    runWalk(32'h3000, VA, 32'h10, 0);
    chk(firstReq == 1'b1 && firstReqAddr == 30'hC00, "R2", "first read word address",
        64'(firstReqAddr), 64'hC00);
    expectWalk("R6", 2'd0, 32'h100, 32'h1FF, 0, 0);

    // R6 R10: vendor high matches, low differs
    runWalk(32'h3000, VB, 32'h10, 0);
    expectWalk("R10", 2'd1, 0, 0, 0, 0);

    // R3: bad identification word at the root
    clearMem();
    putHdr(0, 3, 8'd1, 32'h5344_422E);
    putDev(64, VA, 32'h10, 32'h100, 32'h1FF);
    runWalk(0, VA, 32'h10, 0);
    expectWalk("R3", 2'd2, 0, 0, 0, 0);
    chk(reqAfter == 1'b0, "R3", "no read after abort", 64'(reqAfter), 0);

    // R4: version other than 1
    putHdr(0, 3, 8'd2, MAGIC);
    runWalk(0, VA, 32'h10, 0);
    expectWalk("R4", 2'd3, 0, 0, 0, 0);

    // R4: count includes the header, record beyond count not visited
    putHdr(0, 2, 8'd1, MAGIC);
    putDev(64, VB, 32'h10, 32'h100, 32'h1FF);
    putDev(128, VA, 32'h10, 32'h200, 32'h2FF);
    runWalk(0, VA, 32'h10, 0);
    expectWalk("R4", 2'd1, 0, 0, 0, 0);

    // R9: unknown component type warns, then a clean walk clears flags
    clearMem();
    putHdr(0, 4, 8'd1, MAGIC);
    putOther(64, 8'h05);
    putOther(128, 8'h00);
    putOther(192, 8'hFF);
    runWalk(0, VA, 32'h10, 0);
    expectWalk("R9", 2'd1, 0, 0, 1, 0);
    putOther(64, 8'hC1);
    runWalk(0, VA, 32'h10, 0);
    expectWalk("R9", 2'd1, 0, 0, 0, 0);

    // R7: four nested bridges, bases accumulate
    clearMem();
    buildChain(4, 32'h10, 0);
    runWalk(0, VA, 32'h10, 0);
    expectWalk("R7", 2'd0, 32'h420, 32'h43F, 0, 0);

    // R8 R7: fifth bridge skipped, walk unwinds and finds root device
    clearMem();
    buildChain(5, 32'h11, 1);
    runWalk(0, VA, 32'h11, 0);
    expectWalk("R8", 2'd0, 32'h700, 32'h7FF, 0, 1);
    runWalk(0, VA, 32'h10, 0);
    expectWalk("R8", 2'd1, 0, 0, 0, 1);

    // R3: child table with a bad identification word
    clearMem();
    buildChain(2, 32'h10, 0);
    wr(32'h800, 32'h0);
    runWalk(0, VA, 32'h10, 0);
    expectWalk("R3", 2'd2, 0, 0, 0, 0);

    // Random two-level tables against the walk model (R5 R6 R7 R9 R10)
    for (int it = 0; it < 60; it++) begin
      clearMem();
      randTable(32'h0, 0);
      randTable(32'h800, 1);
      randTable(32'h1000, 2);
      for (int k = 0; k < 2; k++) begin
        logic [63:0] v;
        logic [31:0] d;
        v = {32'h8000_0001 + 32'($urandom % 2), 32'hA + 32'($urandom % 2)};
        d = 32'h10 + 32'($urandom % 2);
        refWalk(0, v, d, eSt, eF, eL, eW, eO);
        runWalk(0, v, d, 0);
        expectWalk("R7", eSt, eF, eL, eW, eO);
      end
    end

    summary();
    $finish;
  end

endmodule